// File: doc/BRIEF.md
# Ethernet PHY Status LED Controller

This block drives the five status LEDs of a 10/100 Ethernet transceiver. The first four LEDs show duplex or polarity, collision, link or traffic, and receive activity. The fifth shows transmit activity.

It takes the following inputs:
- link, speed, duplex, inverted-polarity and collision status levels;
- one-cycle transmit and receive activity strobes;
- two mode bits from a configuration register.

All of these are plain synchronous inputs. Every LED output is active low and registered. A pin at 0 means the LED is lit.

The two mode bits change what two of the pins mean:
- **Polarity mode.** The duplex pin instead shows that the 10 Mbps receive polarity is inverted.
- **Traffic mode.** The link pin becomes a traffic LED. It stays steadily lit while the link is good and blinks while there is activity.

The receive and transmit LEDs each go through a retriggerable monostable stretcher, so that a single-cycle strobe stays visible for a minimum time. The blink in traffic mode comes from a free-running toggle generator.

Top module: `phy_led_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears all internal counters. At the clock edge after `rst` is sampled high, all five LED outputs are 1 (off).
- R2: With `cfg_pol_mode`=0, `dup_led_n` is the inverse of `fdx` sampled at the previous clock edge. The one-cycle output register latency applies to every status LED.
- R3: With `cfg_pol_mode`=1, `dup_led_n` is 0 exactly when `pol_inv`=1 and `spd10`=1 were sampled at the previous edge. Otherwise it is 1.
- R4: With `cfg_traffic_mode`=0, `lnk_led_n` is the inverse of `link_ok` sampled at the previous edge. Activity has no effect on it.
- R5: `col_led_n` is 0 exactly when `col`=1 and `fdx`=0 were sampled at the previous edge. A collision in full-duplex never lights it.
- R6: With `cfg_traffic_mode`=1 and `link_ok`=1, `lnk_led_n` is steadily 0 whenever neither stretched activity signal is asserted.
- R7: A single `tx_stb` (or `rx_stb`) pulse sampled at edge k drives `tx_led_n` (or `rx_led_n`) to 0 from edge k+1 for exactly `STRETCH_CYC` cycles, then back to 1.
- R8: A new strobe that arrives while the stretcher is running reloads it. The LED then stays lit for `STRETCH_CYC` cycles after the last strobe's edge.
- R9: With `cfg_traffic_mode`=1, `link_ok`=1 and either stretched activity asserted, `lnk_led_n` follows a free-running blink phase.
  - The phase toggles every `BLINK_HALF` cycles.
  - The phase counts from reset.
  - The lit half comes first.
- R10: With `link_ok`=0 sampled at the previous edge, `lnk_led_n` is 1 in both link modes, whatever the activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_ok | input | 1 | Link good status |
| spd10 | input | 1 | 1 = 10 Mbps operation, 0 = 100 Mbps |
| fdx | input | 1 | Full-duplex mode active |
| pol_inv | input | 1 | 10 Mbps receive polarity is inverted |
| col | input | 1 | Collision detected |
| tx_stb | input | 1 | One-cycle transmit activity strobe |
| rx_stb | input | 1 | One-cycle receive activity strobe |
| cfg_pol_mode | input | 1 | 1 = duplex pin shows polarity |
| cfg_traffic_mode | input | 1 | 1 = link pin acts as traffic LED |
| dup_led_n | output | 1 | Duplex / polarity LED, active low |
| col_led_n | output | 1 | Collision LED, active low |
| lnk_led_n | output | 1 | Link / traffic LED, active low |
| rx_led_n | output | 1 | Receive activity LED, active low |
| tx_led_n | output | 1 | Transmit activity LED, active low |

## Verification
The assertions take for granted that every input is synchronous to `clk` and already free of glitches. They also assume reset is held high from the first edge, so that no check looks at a counter value from before reset.

The stimulus changes inputs only at the falling edge and respects these assumptions. It runs with a short stretch time and a short blink half-period. Strobe gaps are therefore both shorter and longer than the stretch time, and blink wraps happen inside every activity window. The mode bits are swept across all four combinations, and link-down windows are mixed with strobe traffic.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

   // activity channel indices
   localparam int unsigned ACT_TX  = 0;
   localparam int unsigned ACT_RX  = 1;
   localparam int unsigned NUM_ACT = 2;

   // lit flags for the five LEDs, active high internally
   typedef struct packed {
      logic dup;
      logic col;
      logic lnk;
      logic rx;
      logic tx;
   } led_lit_t;

   localparam led_lit_t ALL_DARK = '{dup: 1'b0, col: 1'b0, lnk: 1'b0, rx: 1'b0, tx: 1'b0};

endpackage

// File: rtl/phy_led_stretch.sv
module phy_led_stretch #(
   parameter int unsigned HOLD_CYC = 12_500_000
) (
   input  logic clk,
   input  logic rst,
   input  logic stb,
   output logic active
);

   localparam int unsigned CW = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (stb) begin
         cnt <= LOAD;
      end else if (cnt != '0) begin
         cnt <= cnt - CW'(1);
      end
   end

   assign active = (cnt != '0);

   // a stretch ends only after a full countdown with no fresh strobe
   assert_reload_end_R8 : assert property (@(posedge clk) disable iff (rst)
      $fell(active) |-> ($past(cnt) == CW'(1) && !$past(stb)));

   // a strobe always restarts the window at its full length
   assert_reload_full_R8 : assert property (@(posedge clk) disable iff (rst)
      stb |=> (active && cnt == LOAD));

endmodule

// File: rtl/phy_led_blink.sv
module phy_led_blink #(
   parameter int unsigned HALF_CYC = 12_500_000
) (
   input  logic clk,
   input  logic rst,
   output logic lit_phase
);

   localparam int unsigned BW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [BW-1:0] LAST = BW'(HALF_CYC - 1);

   logic [BW-1:0] cnt;
   logic          dark;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         dark <= 1'b0;
      end else if (cnt == LAST) begin
         cnt  <= '0;
         dark <= ~dark;
      end else begin
         cnt  <= cnt + BW'(1);
      end
   end

   assign lit_phase = ~dark;

   // the phase only flips at the end of a half period
   assert_blink_rate_R9 : assert property (@(posedge clk) disable iff (rst)
      (!$stable(dark) && !$past(rst)) |-> ($past(cnt) == LAST));

endmodule

// File: rtl/phy_led_select.sv
module phy_led_select
   import phy_led_pkg::*;
(
   input  logic     link_ok,
   input  logic     spd10,
   input  logic     fdx,
   input  logic     pol_inv,
   input  logic     col,
   input  logic     cfg_pol_mode,
   input  logic     cfg_traffic_mode,
   input  logic     tx_act,
   input  logic     rx_act,
   input  logic     blink_lit,
   output led_lit_t lit
);

   logic any_act;
   logic traffic_lit;

   assign any_act     = tx_act | rx_act;
   assign traffic_lit = link_ok & (~any_act | blink_lit);

   always_comb begin
      lit     = ALL_DARK;
      lit.dup = cfg_pol_mode ? (pol_inv & spd10) : fdx;
      lit.col = col & ~fdx;
      lit.lnk = cfg_traffic_mode ? traffic_lit : link_ok;
      lit.rx  = rx_act;
      lit.tx  = tx_act;
   end

endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
   import phy_led_pkg::*;
#(
   parameter int unsigned STRETCH_CYC = 12_500_000,
   parameter int unsigned BLINK_HALF  = 12_500_000
) (
   input  logic clk,
   input  logic rst,
   input  logic link_ok,
   input  logic spd10,
   input  logic fdx,
   input  logic pol_inv,
   input  logic col,
   input  logic tx_stb,
   input  logic rx_stb,
   input  logic cfg_pol_mode,
   input  logic cfg_traffic_mode,
   output logic dup_led_n,
   output logic col_led_n,
   output logic lnk_led_n,
   output logic rx_led_n,
   output logic tx_led_n
);

   if (STRETCH_CYC < 1) begin : g_bad_stretch
      $error("STRETCH_CYC must be at least 1");
   end
   if (BLINK_HALF < 2) begin : g_bad_blink
      $error("BLINK_HALF must be at least 2");
   end

   logic [NUM_ACT-1:0] stb_vec;
   logic [NUM_ACT-1:0] act_vec;
   logic               blink_lit;
   led_lit_t           lit;

   assign stb_vec[ACT_TX] = tx_stb;
   assign stb_vec[ACT_RX] = rx_stb;

   for (genvar i = 0; i < NUM_ACT; i++) begin : g_act
      phy_led_stretch #(.HOLD_CYC(STRETCH_CYC)) u_stretch (
         .clk    (clk),
         .rst    (rst),
         .stb    (stb_vec[i]),
         .active (act_vec[i])
      );
   end

   phy_led_blink #(.HALF_CYC(BLINK_HALF)) u_blink (
      .clk       (clk),
      .rst       (rst),
      .lit_phase (blink_lit)
   );

   phy_led_select u_sel (
      .link_ok          (link_ok),
      .spd10            (spd10),
      .fdx              (fdx),
      .pol_inv          (pol_inv),
      .col              (col),
      .cfg_pol_mode     (cfg_pol_mode),
      .cfg_traffic_mode (cfg_traffic_mode),
      .tx_act           (act_vec[ACT_TX]),
      .rx_act           (act_vec[ACT_RX]),
      .blink_lit        (blink_lit),
      .lit              (lit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         dup_led_n <= 1'b1;
         col_led_n <= 1'b1;
         lnk_led_n <= 1'b1;
         rx_led_n  <= 1'b1;
         tx_led_n  <= 1'b1;
      end else begin
         dup_led_n <= ~lit.dup;
         col_led_n <= ~lit.col;
         lnk_led_n <= ~lit.lnk;
         rx_led_n  <= ~lit.rx;
         tx_led_n  <= ~lit.tx;
      end
   end

   assert_reset_dark_R1 : assert property (@(posedge clk)
      rst |=> (dup_led_n && col_led_n && lnk_led_n && rx_led_n && tx_led_n));

   assert_col_fdx_R5 : assert property (@(posedge clk) disable iff (rst)
      !col_led_n |-> $past(col && !fdx));

   assert_link_down_R10 : assert property (@(posedge clk) disable iff (rst)
      !link_ok |=> lnk_led_n);

   assert_tx_stretch_R7 : assert property (@(posedge clk) disable iff (rst)
      tx_stb |-> ##2 !tx_led_n);

   assert_rx_stretch_R7 : assert property (@(posedge clk) disable iff (rst)
      rx_stb |-> ##2 !rx_led_n);

   assert_link_plain_R4 : assert property (@(posedge clk) disable iff (rst)
      (link_ok && !cfg_traffic_mode) |=> !lnk_led_n);

endmodule

// File: tb/phy_led_ctrl_test.sv
module phy_led_ctrl_test;

   localparam int STRETCH = 9;
   localparam int HALF    = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic link_ok = 0, spd10 = 0, fdx = 0, pol_inv = 0, col = 0;
   logic tx_stb = 0, rx_stb = 0, cfg_pol_mode = 0, cfg_traffic_mode = 0;
   logic dup_led_n, col_led_n, lnk_led_n, rx_led_n, tx_led_n;

   always #2 clk = ~clk;

   phy_led_ctrl #(.STRETCH_CYC(STRETCH), .BLINK_HALF(HALF)) uut (
      .clk(clk), .rst(rst), .link_ok(link_ok), .spd10(spd10), .fdx(fdx),
      .pol_inv(pol_inv), .col(col), .tx_stb(tx_stb), .rx_stb(rx_stb),
      .cfg_pol_mode(cfg_pol_mode), .cfg_traffic_mode(cfg_traffic_mode),
      .dup_led_n(dup_led_n), .col_led_n(col_led_n), .lnk_led_n(lnk_led_n),
      .rx_led_n(rx_led_n), .tx_led_n(tx_led_n)
   );

   int tests = 0;
   int fails = 0;
   int cyc   = 0;
   bit chk_en = 0;
   bit done   = 0;

   // behavioural reference state
   int tx_left = 0, rx_left = 0, bl_cnt = 0;
   bit bl_dark = 0;
   logic e_dup = 1, e_col = 1, e_lnk = 1, e_rx = 1, e_tx = 1;
   string t_dup = "R2", t_lnk = "R4";

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst) begin
         tx_left = 0; rx_left = 0; bl_cnt = 0; bl_dark = 0;
         e_dup = 1; e_col = 1; e_lnk = 1; e_rx = 1; e_tx = 1;
         t_dup = "R1"; t_lnk = "R1";
      end else begin
         bit busy;
         busy  = (tx_left > 0) || (rx_left > 0);
         e_dup = cfg_pol_mode ? !(pol_inv && spd10) : !fdx;
         t_dup = cfg_pol_mode ? "R3" : "R2";
         e_col = !(col && !fdx);
         if (!link_ok) begin
            e_lnk = 1; t_lnk = "R10";
         end else if (!cfg_traffic_mode) begin
            e_lnk = 0; t_lnk = "R4";
         end else if (!busy) begin
            e_lnk = 0; t_lnk = "R6";
         end else begin
            e_lnk = bl_dark; t_lnk = "R9";
         end
         e_tx = !(tx_left > 0);
         e_rx = !(rx_left > 0);
         if (tx_stb) tx_left = STRETCH; else if (tx_left > 0) tx_left--;
         if (rx_stb) rx_left = STRETCH; else if (rx_left > 0) rx_left--;
         if (bl_cnt == HALF - 1) begin bl_cnt = 0; bl_dark = !bl_dark; end
         else bl_cnt++;
      end
   end

   task automatic check(string tag, string name, logic act, logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, name, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (chk_en) begin
         check(t_dup, "dup_led_n", dup_led_n, e_dup);
         check("R5", "col_led_n", col_led_n, e_col);
         check(t_lnk, "lnk_led_n", lnk_led_n, e_lnk);
         check("R7", "rx_led_n", rx_led_n, e_rx);
         check("R7", "tx_led_n", tx_led_n, e_tx);
      end
   end

   // pseudo-random source
   logic [15:0] lfsr = 16'hACE1;
   function automatic logic [15:0] step(logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tx_stb = 0; rx_stb = 0;
      end
   endtask

   // count lit cycles of tx_led_n after stimulus
   task automatic count_tx(input int gap, input string tag, input int exp_len);
      int lit = 0;
      @(negedge clk); tx_stb = 1;
      @(negedge clk); tx_stb = 0;
      for (int i = 0; i < STRETCH + gap + 6; i++) begin
         if (i == gap && gap > 0) tx_stb = 1; else tx_stb = 0;
         if (!tx_led_n) lit++;
         @(negedge clk);
      end
      tx_stb = 0;
      tests++;
      if (lit != exp_len) begin
         fails++;
         $display("FAIL %s tx lit cycles actual=%0d expected=%0d", tag, lit, exp_len);
      end
   endtask

   task automatic run_random(int n, bit pmode, bit tmode, int strobe_mask);
      cfg_pol_mode = pmode; cfg_traffic_mode = tmode;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         lfsr = step(lfsr);
         tx_stb = ((lfsr & 16'(strobe_mask)) == 0);
         lfsr = step(lfsr);
         rx_stb = ((lfsr & 16'(strobe_mask)) == 0);
         if (i % 7 == 0) begin
            lfsr = step(lfsr);
            {spd10, fdx, pol_inv, col} = lfsr[3:0];
            link_ok = (lfsr[7:5] != 3'b000);
         end
      end
      @(negedge clk); tx_stb = 0; rx_stb = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_en = 1;
      // R1: outputs dark while reset held
      check("R1", "all_leds_reset", dup_led_n & col_led_n & lnk_led_n & rx_led_n & tx_led_n, 1'b1);
      rst = 0;
      link_ok = 1;
      idle(3);
      // R7: single strobe lit for exactly STRETCH cycles
      count_tx(0, "R7", STRETCH);
      // R8: retrigger 5 cycles after the first strobe extends the window
      count_tx(4, "R8", STRETCH + 5);
      // R5: collision in full duplex stays dark
      fdx = 1; col = 1; idle(3);
      check("R5", "col_fdx", col_led_n, 1'b1);
      fdx = 0; idle(2);
      check("R5", "col_hdx", col_led_n, 1'b0);
      col = 0;
      // R10: link down in traffic mode with activity
      cfg_traffic_mode = 1; link_ok = 0;
      @(negedge clk); rx_stb = 1; idle(4);
      check("R10", "lnk_down_traffic", lnk_led_n, 1'b1);
      link_ok = 1;
      for (int m = 0; m < 4; m++) begin
         run_random(300, m[0], m[1], 16'h000F);
         run_random(200, m[0], m[1], 16'h0003);
         idle(STRETCH + 3);
      end
      // reset in mid-activity
      cfg_traffic_mode = 1;
      @(negedge clk); tx_stb = 1;
      @(negedge clk); tx_stb = 0; rst = 1;
      idle(2);
      check("R1", "reset_mid_activity", tx_led_n & lnk_led_n, 1'b1);
      rst = 0;
      run_random(300, 1'b0, 1'b1, 16'h0007);
      idle(4);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule